// File: doc/BRIEF.md
# Way-Partitioned Cache Allocation Mask Generator

This block sits beside the tag pipeline of a 12-way set-associative cache. The cache is shared by many slices, and each slice holds its own partition attributes in two register words. When an access arrives with a slice number and that slice's current line count, the block returns three results in the same cycle. The first is the set of ways to look up for a hit. The second is the set of ways the fill may replace. The third is a flag that reports when a fill is refused because a size-capped slice has no room.

A slice owns reserved ways, which no other slice may fill. It may also use shared bonus ways, but only those that no other slice has reserved. A slice can limit its lookup to its own reserved and bonus ways. A slice marked fixed-size stops growing once its line count reaches its capacity. After that it may refill only inside its reserved ways. The block also reports the lowest-numbered allowed way as the victim choice, along with the slice's replacement priority and cache mode, so that the replacement logic can use them.

Top module: `wpart_alloc_mask_gen`

## Requirements
- R1: After reset, every slice has zero reserved ways, zero bonus ways, probing over all ways, no size cap, priority 0 and mode 0. A request after reset therefore gives probe mask 0xFFF, allocation mask 0 and no victim.
- R2: A write to address 0x21000 + 8*s sets slice s's reserved mask from data bits [11:0] and its bonus mask from bits [27:16]. The new values are used from the cycle after the write edge.
- R3: A write to address 0x21004 + 8*s sets slice s's settings word, from the cycle after the write edge:
  - mode from bits [1:0];
  - own-ways-only probe flag from bit 2;
  - fixed-size flag from bit 3;
  - priority from bits [6:4];
  - capacity from bits [31:16].
  The capacity is the per-bank line count, KB*1024/banks >> 6.
- R4: A write is ignored, and leaves every slice's attributes unchanged, in any of these cases:
  - its address is below 0x21000;
  - its address is at or above 0x21000 + 8*NUM_SLICES;
  - its address is not a multiple of 4.
- R5: When the own-ways-only flag is 1, the probe mask is the slice's reserved OR bonus ways. When the flag is 0, the probe mask is all ones.
- R6: The allocation mask is the slice's reserved ways, plus those of its bonus ways that appear in no other slice's reserved mask.
- R7: A fixed-size slice with occupancy >= capacity has an allocation mask of only its reserved ways. Occupancy has no effect on a slice that is not fixed-size.
- R8: grow_denied is 1 exactly when a fixed-size slice is at capacity and reserves no ways. The allocation mask is then 0.
- R9: victim_valid is 1 when the allocation mask is nonzero. victim_way is then the lowest set bit position of the allocation mask.
- R10: req_priority and req_mode give the requesting slice's stored priority and mode.
- R11: With req_valid low, all outputs except the clock-free state are 0: both masks, grow_denied, victim_valid, victim_way, req_priority and req_mode.
- R12: All request outputs are combinational from the request inputs and the stored attributes, and are valid in the same cycle as the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Attribute register write strobe |
| wr_addr | input | 32 | Write byte address |
| wr_data | input | 32 | Write data |
| req_valid | input | 1 | Access request present |
| req_slice | input | 5 | Requesting slice number |
| req_occupancy | input | 16 | Slice's current line count |
| probe_mask | output | 12 | Ways to look up for a hit |
| alloc_mask | output | 12 | Ways allowed as fill victim |
| grow_denied | output | 1 | Fill refused: capped slice with no reserved ways |
| victim_valid | output | 1 | A victim way is offered |
| victim_way | output | 4 | Offered victim way index |
| req_priority | output | 3 | Slice replacement priority (lower value is more urgent) |
| req_mode | output | 2 | Slice cache mode |

## Verification
The request results are combinational, so the bench drives a request on a falling clock edge and samples all outputs 1 ns later, with no rising edge in between. Attribute writes take effect after exactly one rising edge. The bench therefore drives a write on a falling edge, removes it at the next falling edge, and only then updates its model and issues requests. Assertions placed next to the write decode and the mask logic check, on each rising edge, the write capture, the rejection of stray writes, and the set relations between the masks.

// File: rtl/wpart_pkg.sv
package wpart_pkg;

  // Field positions inside the two per-slice attribute words.
  localparam int RES_LSB   = 0;
  localparam int BONUS_LSB = 16;
  localparam int MODE_LSB  = 0;
  localparam int PTW_BIT   = 2;
  localparam int FIXED_BIT = 3;
  localparam int PRIO_LSB  = 4;
  localparam int CAP_LSB   = 16;

  localparam int MODE_W = 2;
  localparam int PRIO_W = 3;
  localparam int CAP_W  = 16;

  typedef struct packed {
    logic [CAP_W-1:0]  cap;
    logic [PRIO_W-1:0] prio;
    logic              fixed_sz;
    logic              probe_own;
    logic [MODE_W-1:0] mode;
  } slice_cfg_t;

  // Size cap reached for a fixed-size slice.
  function automatic logic at_capacity(input logic fixed_sz,
                                       input logic [CAP_W-1:0] occ,
                                       input logic [CAP_W-1:0] cap);
    return fixed_sz && (occ >= cap);
  endfunction

endpackage

// File: rtl/wpart_attr_regs.sv
module wpart_attr_regs
  import wpart_pkg::*;
#(
  parameter int          NUM_WAYS   = 12,
  parameter int          NUM_SLICES = 32,
  parameter int          ADDR_W     = 32,
  parameter logic [31:0] BASE_ADDR  = 32'h0002_1000
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wr_en,
  input  logic [ADDR_W-1:0]                    wr_addr,
  input  logic [31:0]                          wr_data,
  output logic [NUM_SLICES-1:0][NUM_WAYS-1:0]  res_q,
  output logic [NUM_SLICES-1:0][NUM_WAYS-1:0]  bonus_q,
  output slice_cfg_t [NUM_SLICES-1:0]          cfg_q
);
  localparam int SLICE_W = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1;
  localparam int SPAN    = 8 * NUM_SLICES;

  logic [ADDR_W-1:0]     offset;
  logic                  in_window;
  logic [SLICE_W-1:0]    sel_idx;
  logic                  sel_word1;
  logic [NUM_SLICES-1:0] hit_w0;
  logic [NUM_SLICES-1:0] hit_w1;
  logic                  unused_bits;

  assign unused_bits = ^wr_data[15:12];
  assign offset      = wr_addr - ADDR_W'(BASE_ADDR);
  assign in_window   = (wr_addr >= ADDR_W'(BASE_ADDR)) &&
                       (offset < ADDR_W'(SPAN)) && (offset[1:0] == 2'b00);
  assign sel_idx     = offset[SLICE_W+2:3];
  assign sel_word1   = offset[2];

  for (genvar g = 0; g < NUM_SLICES; g++) begin : g_slice
    assign hit_w0[g] = wr_en && in_window && !sel_word1 && (sel_idx == SLICE_W'(g));
    assign hit_w1[g] = wr_en && in_window &&  sel_word1 && (sel_idx == SLICE_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        res_q[g]   <= '0;
        bonus_q[g] <= '0;
      end else if (hit_w0[g]) begin
        res_q[g]   <= wr_data[RES_LSB +: NUM_WAYS];
        bonus_q[g] <= wr_data[BONUS_LSB +: NUM_WAYS];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[g] <= '0;
      end else if (hit_w1[g]) begin
        cfg_q[g] <= slice_cfg_t'({wr_data[CAP_LSB +: CAP_W],
                                  wr_data[PRIO_LSB +: PRIO_W],
                                  wr_data[FIXED_BIT],
                                  wr_data[PTW_BIT],
                                  wr_data[MODE_LSB +: MODE_W]});
      end
    end

    // R2: a mask-word write lands in the addressed slice on the next edge
    assert_w0_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
      hit_w0[g] |=> (res_q[g] == $past(wr_data[RES_LSB +: NUM_WAYS])) &&
                    (bonus_q[g] == $past(wr_data[BONUS_LSB +: NUM_WAYS])));

    // R3: a settings-word write lands in the addressed slice on the next edge
    assert_w1_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
      hit_w1[g] |=> (cfg_q[g].cap == $past(wr_data[CAP_LSB +: CAP_W])) &&
                    (cfg_q[g].prio == $past(wr_data[PRIO_LSB +: PRIO_W])));
  end

  // R4: a write outside the attribute window changes nothing
  assert_stray_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !in_window) |=> $stable(res_q) && $stable(bonus_q) && $stable(cfg_q));

endmodule

// File: rtl/wpart_mask_logic.sv
module wpart_mask_logic
  import wpart_pkg::*;
#(
  parameter int NUM_WAYS   = 12,
  parameter int NUM_SLICES = 32,
  localparam int SLICE_W   = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 req_valid,
  input  logic [SLICE_W-1:0]                   req_slice,
  input  logic [CAP_W-1:0]                     req_occ,
  input  logic [NUM_SLICES-1:0][NUM_WAYS-1:0]  res_q,
  input  logic [NUM_SLICES-1:0][NUM_WAYS-1:0]  bonus_q,
  input  slice_cfg_t [NUM_SLICES-1:0]          cfg_q,
  output logic [NUM_WAYS-1:0]                  probe_mask,
  output logic [NUM_WAYS-1:0]                  alloc_mask,
  output logic                                 grow_denied,
  output logic [PRIO_W-1:0]                    req_priority,
  output logic [MODE_W-1:0]                    req_mode
);
  // Named internal events for the assertions below.
  logic [NUM_WAYS-1:0] own_res;
  logic [NUM_WAYS-1:0] own_bonus;
  logic [NUM_WAYS-1:0] foreign_res;
  logic [NUM_WAYS-1:0] shared_free;
  slice_cfg_t          sel_cfg;
  logic                capped;

  assign own_res   = res_q[req_slice];
  assign own_bonus = bonus_q[req_slice];
  assign sel_cfg   = cfg_q[req_slice];

  always_comb begin
    foreign_res = '0;
    for (int k = 0; k < NUM_SLICES; k++) begin
      if (SLICE_W'(k) != req_slice) foreign_res = foreign_res | res_q[k];
    end
  end

  assign shared_free = own_bonus & ~foreign_res;
  assign capped      = at_capacity(sel_cfg.fixed_sz, req_occ, sel_cfg.cap);

  always_comb begin
    probe_mask   = '0;
    alloc_mask   = '0;
    grow_denied  = 1'b0;
    req_priority = '0;
    req_mode     = '0;
    if (req_valid) begin
      probe_mask   = sel_cfg.probe_own ? (own_res | own_bonus) : '1;
      alloc_mask   = capped ? own_res : (own_res | shared_free);
      grow_denied  = capped && (own_res == '0);
      req_priority = sel_cfg.prio;
      req_mode     = sel_cfg.mode;
    end
  end

  // R5: fill candidates are always among the probed ways
  assert_alloc_in_probe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_mask & ~probe_mask) == '0);

  // R6: another slice's reserved way is never offered unless also owned here
  assert_no_foreign_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (alloc_mask & foreign_res & ~own_res) == '0);

  // R7: a capped slice allocates only inside its reserved ways
  assert_capped_res_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && capped) |-> (alloc_mask & ~own_res) == '0);

  // R8: a refused fill offers no ways
  assert_denied_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    grow_denied |-> (alloc_mask == '0) && capped);

endmodule

// File: rtl/wpart_victim_pick.sv
module wpart_victim_pick #(
  parameter int NUM_WAYS = 12,
  localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_WAYS-1:0] alloc_mask,
  output logic                victim_valid,
  output logic [WAY_W-1:0]    victim_way
);
  function automatic logic [WAY_W-1:0] lowest_way(input logic [NUM_WAYS-1:0] m);
    logic [WAY_W-1:0] idx;
    idx = '0;
    for (int i = NUM_WAYS - 1; i >= 0; i--) begin
      if (m[i]) idx = WAY_W'(i);
    end
    return idx;
  endfunction

  assign victim_valid = |alloc_mask;
  assign victim_way   = lowest_way(alloc_mask);

  // R9: offered way is allowed and no lower-numbered way is allowed
  assert_victim_lowest_R9: assert property (@(posedge clk) disable iff (!rst_n)
    victim_valid |-> alloc_mask[victim_way] &&
                     ((alloc_mask & ~({NUM_WAYS{1'b1}} << victim_way)) == '0));

  assert_victim_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !victim_valid |-> (victim_way == '0) && (alloc_mask == '0));

endmodule

// File: rtl/wpart_alloc_mask_gen.sv
module wpart_alloc_mask_gen
  import wpart_pkg::*;
#(
  parameter int          NUM_WAYS   = 12,
  parameter int          NUM_SLICES = 32,
  parameter int          ADDR_W     = 32,
  parameter logic [31:0] BASE_ADDR  = 32'h0002_1000,
  localparam int         SLICE_W    = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1,
  localparam int         WAY_W      = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [31:0]         wr_data,
  input  logic                req_valid,
  input  logic [SLICE_W-1:0]  req_slice,
  input  logic [CAP_W-1:0]    req_occupancy,
  output logic [NUM_WAYS-1:0] probe_mask,
  output logic [NUM_WAYS-1:0] alloc_mask,
  output logic                grow_denied,
  output logic                victim_valid,
  output logic [WAY_W-1:0]    victim_way,
  output logic [PRIO_W-1:0]   req_priority,
  output logic [MODE_W-1:0]   req_mode
);
  logic [NUM_SLICES-1:0][NUM_WAYS-1:0] res_q;
  logic [NUM_SLICES-1:0][NUM_WAYS-1:0] bonus_q;
  slice_cfg_t [NUM_SLICES-1:0]         cfg_q;

  wpart_attr_regs #(
    .NUM_WAYS(NUM_WAYS), .NUM_SLICES(NUM_SLICES),
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .res_q(res_q), .bonus_q(bonus_q), .cfg_q(cfg_q)
  );

  wpart_mask_logic #(
    .NUM_WAYS(NUM_WAYS), .NUM_SLICES(NUM_SLICES)
  ) u_masks (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_slice(req_slice),
    .req_occ(req_occupancy), .res_q(res_q), .bonus_q(bonus_q), .cfg_q(cfg_q),
    .probe_mask(probe_mask), .alloc_mask(alloc_mask), .grow_denied(grow_denied),
    .req_priority(req_priority), .req_mode(req_mode)
  );

  wpart_victim_pick #(
    .NUM_WAYS(NUM_WAYS)
  ) u_victim (
    .clk(clk), .rst_n(rst_n), .alloc_mask(alloc_mask),
    .victim_valid(victim_valid), .victim_way(victim_way)
  );

  // R11: an idle request port drives every result to zero
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (probe_mask == '0) && (alloc_mask == '0) && !grow_denied &&
                   !victim_valid && (req_priority == '0) && (req_mode == '0));

endmodule

// File: tb/tb_wpart_alloc_mask_gen.sv
`timescale 1ns/1ps
module tb_wpart_alloc_mask_gen;
  localparam int          NS   = 32;
  localparam logic [31:0] BASE = 32'h0002_1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        req_valid = 1'b0;
  logic [4:0]  req_slice = '0;
  logic [15:0] req_occupancy = '0;
  logic [11:0] probe_mask, alloc_mask;
  logic        grow_denied, victim_valid;
  logic [3:0]  victim_way;
  logic [2:0]  req_priority;
  logic [1:0]  req_mode;

  int n_checks = 0;
  int n_err = 0;

  logic [11:0] m_res   [NS];
  logic [11:0] m_bonus [NS];
  logic [31:0] m_w1    [NS];

  always #10 clk = ~clk;

  wpart_alloc_mask_gen dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .req_valid(req_valid), .req_slice(req_slice), .req_occupancy(req_occupancy),
    .probe_mask(probe_mask), .alloc_mask(alloc_mask), .grow_denied(grow_denied),
    .victim_valid(victim_valid), .victim_way(victim_way),
    .req_priority(req_priority), .req_mode(req_mode)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Per-bank line count from kilobytes and bank count.
  function automatic logic [15:0] lines_per_bank(input int kb, input int banks);
    return 16'((kb * 1024 / banks) >> 6);
  endfunction

  function automatic logic [11:0] e_foreign(input int s);
    logic [11:0] f = '0;
    for (int k = 0; k < NS; k++) if (k != s) f |= m_res[k];
    return f;
  endfunction

  function automatic logic e_capped(input int s, input int occ);
    return m_w1[s][3] && (occ >= int'(m_w1[s][31:16]));
  endfunction

  function automatic logic [11:0] e_probe(input int s);
    return m_w1[s][2] ? (m_res[s] | m_bonus[s]) : 12'hFFF;
  endfunction

  function automatic logic [11:0] e_alloc(input int s, input int occ);
    if (e_capped(s, occ)) return m_res[s];
    return m_res[s] | (m_bonus[s] & ~e_foreign(s));
  endfunction

  function automatic logic [3:0] e_lowest(input logic [11:0] m);
    for (int i = 0; i < 12; i++) if (m[i]) return 4'(i);
    return 4'd0;
  endfunction

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a >= BASE && a < BASE + 32'(8 * NS) && a[1:0] == 2'b00) begin
      int s;
      s = int'((a - BASE) >> 3);
      if ((a - BASE) & 32'h4) m_w1[s] = d;
      else begin
        m_res[s]   = d[11:0];
        m_bonus[s] = d[27:16];
      end
    end
  endtask

  // R12: outputs sampled 1 ns after the request change, no clock edge between.
  task automatic chk_req(input string tag, input int s, input int occ, input logic v);
    logic [11:0] ea;
    @(negedge clk);
    req_valid = v; req_slice = 5'(s); req_occupancy = 16'(occ);
    #1;
    ea = v ? e_alloc(s, occ) : 12'h000;
    check(tag, "probe_mask", 32'(probe_mask), v ? 32'(e_probe(s)) : 32'd0);
    check(tag, "alloc_mask", 32'(alloc_mask), 32'(ea));
    check(tag, "grow_denied", 32'(grow_denied),
          32'(v && e_capped(s, occ) && m_res[s] == 12'h000));
    check(tag, "victim_valid", 32'(victim_valid), 32'(ea != 12'h000));
    check(tag, "victim_way", 32'(victim_way), 32'(e_lowest(ea)));
    check(tag, "req_priority", 32'(req_priority), v ? 32'(m_w1[s][6:4]) : 32'd0);
    check(tag, "req_mode", 32'(req_mode), v ? 32'(m_w1[s][1:0]) : 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    for (int k = 0; k < NS; k++) begin
      m_res[k] = '0; m_bonus[k] = '0; m_w1[k] = '0;
    end
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk_req("R1", 0, 0, 1'b1);
    chk_req("R1", 31, 500, 1'b1);

    // R2 / R6: reserved and bonus sharing
    wr(BASE + 8*1, 32'h0FFC_F002);        // res 0x002, bonus 0xFFC, junk in [15:12]
    wr(BASE + 8*2, 32'h0000_00F0);        // res 0x0F0
    chk_req("R2", 1, 0, 1'b1);
    chk_req("R6", 1, 0, 1'b1);            // bonus minus slice 2 reserved
    chk_req("R6", 2, 0, 1'b1);

    // R3 / R5 / R10: settings word, own-ways probing, priority and mode
    wr(BASE + 8*1 + 4, {16'd0, 9'd0, 3'd5, 1'b0, 1'b1, 2'd2});
    chk_req("R5", 1, 0, 1'b1);
    chk_req("R10", 1, 0, 1'b1);
    wr(BASE + 8*1 + 4, {16'd0, 9'd0, 3'd1, 1'b0, 1'b0, 2'd1});
    chk_req("R3", 1, 0, 1'b1);

    // R7: fixed-size cap using a computed per-bank capacity (512 KB over 4 banks)
    wr(BASE + 8*2 + 4, {lines_per_bank(512, 4), 9'd0, 3'd2, 1'b1, 1'b0, 2'd0});
    wr(BASE + 8*2, 32'h0F00_00F0);        // add bonus 0xF00
    chk_req("R7", 2, 2047, 1'b1);         // below capacity: bonus usable
    chk_req("R7", 2, 2048, 1'b1);         // at capacity: reserved only
    chk_req("R7", 1, 65535, 1'b1);        // not fixed-size: occupancy ignored

    // R8: capped slice with bonus ways only
    wr(BASE + 8*3, 32'h000C_0000);
    wr(BASE + 8*3 + 4, {16'd50, 9'd0, 3'd0, 1'b1, 1'b0, 2'd0});
    chk_req("R8", 3, 49, 1'b1);
    chk_req("R8", 3, 50, 1'b1);

    // R9: victim is the lowest allowed way
    wr(BASE + 8*4, 32'h0A00_0400);
    chk_req("R9", 4, 0, 1'b1);

    // R4: stray writes must leave all attributes unchanged
    wr(BASE - 8, 32'hFFFF_FFFF);
    wr(BASE + 32'(8 * NS), 32'hFFFF_FFFF);
    wr(BASE + 8*5 + 1, 32'hFFFF_FFFF);
    wr(BASE + 8*4 + 2, 32'hFFFF_FFFF);
    for (int k = 0; k < 6; k++) chk_req("R4", k, 100, 1'b1);

    // R11: idle request port
    chk_req("R11", 2, 3000, 1'b0);

    // Random mix: R2 R3 R5 R6 R7 R8 R9 R10 R12
    for (int it = 0; it < 600; it++) begin
      logic [31:0] a, d;
      int s, w;
      s = int'($urandom_range(NS - 1, 0));
      w = int'($urandom_range(1, 0));
      if ($urandom_range(9, 0) < 8) a = BASE + 32'(8 * s + 4 * w);
      else a = BASE - 16 + $urandom_range(8 * NS + 32, 0);
      if (w == 0) begin
        d = $urandom;
        d[11:0] = ($urandom_range(3, 0) == 0) ? (12'h001 << $urandom_range(11, 0)) : 12'h000;
      end else begin
        d = $urandom;
        d[31:16] = 16'($urandom_range(200, 0));
      end
      wr(a, d);
      chk_req("R12", int'($urandom_range(NS - 1, 0)), int'($urandom_range(250, 0)),
              $urandom_range(7, 0) != 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule